// File: doc/BRIEF.md
# Single-Level Shadow Context Store

This block keeps one saved copy of four working registers and a small group of arithmetic status flags. An interrupt routine uses it to save and restore context quickly. A save command copies every live value into the shadow storage on one clock edge. A restore command presents the stored values, with a write enable, so the register file and status logic can load them back in the same cycle.

The storage is one level deep. A second save overwrites the first one. The block shows whether a context is currently held, and it flags the two misuse cases. The first is a save that lands on a held context: this happens when a higher-priority routine uses the same mechanism as a routine it interrupted, and the earlier context is lost. The second is a restore when no context is held. Software cannot reach the storage by any path other than these two commands.

The working registers arrive as one packed vector, with register k in bits [k*DW +: DW]. The flags arrive as an NFLAG-bit vector, and the block stores and returns their order unchanged.

Top module: `shadow_ctx`

## Requirements
- R1: After reset, held_o is 0, rest_we_o, clobber_o and underflow_o are 0, and rest_regs_o and rest_flags_o read all zeros.
- R2: When save_i is high at a rising edge, every register word and every flag bit is captured at that edge. From the next cycle, rest_regs_o and rest_flags_o show the captured values.
- R3: rest_we_o is high in exactly the cycles where restore_i is high. During those cycles, rest_regs_o and rest_flags_o carry the stored context as it was before that cycle's edge.
- R4: The storage holds one context only. A second save replaces the whole earlier context.
- R5: held_o becomes 1 after a save and 0 after a restore. When both commands arrive in the same cycle, held_o is 1 afterwards.
- R6: clobber_o is high in a cycle where save_i is high while held_o is 1, and is low otherwise.
- R7: underflow_o is high in a cycle where restore_i is high while held_o is 0, and is low otherwise. Such a restore still asserts rest_we_o and presents the stored values.
- R8: When save and restore arrive in the same cycle, the restore presents the old context, and the new context is stored at that edge.
- R9: Without a save, the stored context does not change, whatever the live inputs or the restore command do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_i | input | 1 | Capture the live context |
| restore_i | input | 1 | Restore the stored context |
| live_regs_i | input | NREG*DW | Live working registers, packed |
| live_flags_i | input | NFLAG | Live status flags |
| rest_regs_o | output | NREG*DW | Stored register context |
| rest_flags_o | output | NFLAG | Stored flag context |
| rest_we_o | output | 1 | Write enable for the restore |
| held_o | output | 1 | A context is held |
| clobber_o | output | 1 | A save is overwriting a held context |
| underflow_o | output | 1 | A restore was issued with nothing held |

## Verification
The bench uses the default parameters: four 16-bit registers and five flags. This makes the packed register word 64 bits wide, so random values fill every lane, including the upper register. Save and restore are each drawn with about even odds, so back-to-back saves, restores on an empty store and same-cycle save-plus-restore all occur many times. This exercises both error pulses and the command overlap.

// File: rtl/shadow_ctx.sv
module shadow_ctx #(
  parameter int DW    = 16,
  parameter int NREG  = 4,
  parameter int NFLAG = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 save_i,
  input  logic                 restore_i,
  input  logic [NREG*DW-1:0]   live_regs_i,
  input  logic [NFLAG-1:0]     live_flags_i,
  output logic [NREG*DW-1:0]   rest_regs_o,
  output logic [NFLAG-1:0]     rest_flags_o,
  output logic                 rest_we_o,
  output logic                 held_o,
  output logic                 clobber_o,
  output logic                 underflow_o
);

  logic [NFLAG-1:0] flg_q;
  logic             held_q;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      word_q <= '0;
      else if (save_i) word_q <= live_regs_i[k*DW +: DW];
    end
    assign rest_regs_o[k*DW +: DW] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q  <= '0;
      held_q <= 1'b0;
    end else begin
      if (save_i) flg_q <= live_flags_i;
      if (save_i)         held_q <= 1'b1;
      else if (restore_i) held_q <= 1'b0;
    end
  end

  assign rest_flags_o = flg_q;
  assign rest_we_o    = restore_i;
  assign held_o       = held_q;
  assign clobber_o    = save_i & held_q;
  assign underflow_o  = restore_i & ~held_q;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    save_i |=> (rest_regs_o == $past(live_regs_i)) && (rest_flags_o == $past(live_flags_i)));

  p_held_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    save_i |=> held_o);

  p_held_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && !save_i) |=> !held_o);

  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !save_i |=> $stable(rest_regs_o) && $stable(rest_flags_o));

  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({clobber_o, underflow_o}) <= 1);

  p_clobber_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && !restore_i) |=> (save_i == clobber_o));

endmodule

// File: tb/shadow_ctx_tb.sv
`timescale 1ns/1ps
module shadow_ctx_tb;
  localparam int DW = 16, NREG = 4, NFLAG = 5;
  localparam int RW = NREG*DW;

  logic clk = 0, rst_n = 0;
  logic save_i = 0, restore_i = 0;
  logic [RW-1:0] live_regs_i = '0;
  logic [NFLAG-1:0] live_flags_i = '0;
  logic [RW-1:0] rest_regs_o;
  logic [NFLAG-1:0] rest_flags_o;
  logic rest_we_o, held_o, clobber_o, underflow_o;

  int errors = 0, checks = 0;
  logic [RW-1:0] m_regs = '0;
  logic [NFLAG-1:0] m_flags = '0;
  logic m_held = 0;

  always #4 clk = ~clk;

  shadow_ctx #(.DW(DW), .NREG(NREG), .NFLAG(NFLAG)) u_dut (
    .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
    .live_regs_i(live_regs_i), .live_flags_i(live_flags_i),
    .rest_regs_o(rest_regs_o), .rest_flags_o(rest_flags_o),
    .rest_we_o(rest_we_o), .held_o(held_o),
    .clobber_o(clobber_o), .underflow_o(underflow_o));

  task automatic chk(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_clobber(logic s, logic h); return s & h; endfunction
  function automatic logic exp_under(logic r, logic h); return r & ~h; endfunction

  task automatic step(logic s, logic r, logic [RW-1:0] regs, logic [NFLAG-1:0] flg);
    @(negedge clk);
    save_i = s; restore_i = r; live_regs_i = regs; live_flags_i = flg;
    #1;
    chk("R2/R4/R9 regs", rest_regs_o, m_regs);
    chk("R2/R4/R9 flags", RW'(rest_flags_o), RW'(m_flags));
    chk("R3 we", RW'(rest_we_o), RW'(r));
    chk("R5 held", RW'(held_o), RW'(m_held));
    chk("R6 clobber", RW'(clobber_o), RW'(exp_clobber(s, m_held)));
    chk("R7 underflow", RW'(underflow_o), RW'(exp_under(r, m_held)));
    @(posedge clk);
    if (s) begin m_regs = regs; m_flags = flg; end
    if (s) m_held = 1; else if (r) m_held = 0;
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 held", RW'(held_o), '0);
    chk("R1 regs", rest_regs_o, '0);
    chk("R1 flags", RW'(rest_flags_o), '0);
    chk("R1 we", RW'(rest_we_o), '0);
    chk("R1 errs", RW'({clobber_o, underflow_o}), '0);
    // R7 restore on empty store
    step(0, 1, 64'h1111_2222_3333_4444, 5'h1f);
    // R2 save, R9 idle cycles keep value
    step(1, 0, 64'hdead_beef_0123_4567, 5'h15);
    step(0, 0, 64'hffff_ffff_ffff_ffff, 5'h0a);
    // R4 second save overwrites, R6 clobber
    step(1, 0, 64'hcafe_f00d_8899_aabb, 5'h0a);
    // R8 simultaneous save and restore
    step(1, 1, 64'h0f0f_f0f0_5a5a_a5a5, 5'h03);
    // R3 restore of held context, then R7 underflow
    step(0, 1, '0, '0);
    step(0, 1, '0, '0);
    step(0, 0, '0, '0);
    for (int i = 0; i < 400; i++)
      step($urandom_range(1, 0), $urandom_range(1, 0),
           {$urandom, $urandom}, NFLAG'($urandom));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule